// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous up counter, four bits wide by default, whose state bits all change together on the rising clock edge. A parallel load, active low, presets the count from a data input at the next edge. Two count enables must both be high for the count to advance. An active-low clear zeroes the count at once, with no clock needed. A carry output goes high at the all-ones count. Only the second enable, `en_t`, qualifies the carry, so stages chain into a wider synchronous counter with no extra gates.

To chain stages, all of them share the clock, clear, load and the first enable `en_p`. Each stage's `en_t` is driven by the carry of the stage below it. The lowest stage has both enables tied to the system count enable.

Each cycle the next-state logic picks one of three named modes:
- **MODE_LOAD** when `ld_n` is low.
- **MODE_COUNT** when `ld_n` is high and both enables are high.
- **MODE_HOLD** in every other case.

The choice is made fresh each cycle, so any mode may follow any other:
- LOAD→COUNT when `ld_n` rises with both enables high.
- COUNT→HOLD when either enable falls.
- HOLD→LOAD when `ld_n` falls.

The asynchronous clear overrides whichever mode is selected.

Top module: `casc_bin_counter`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros; it goes to zero as soon as `clr_n` falls, between clock edges, without waiting for a clock edge.
- R2: With `clr_n` high and `ld_n` low at a rising edge, `q` takes the value of `din` at that edge, whatever `en_p` and `en_t` are.
- R3: With `clr_n` and `ld_n` high and both `en_p` and `en_t` high at a rising edge, `q` increases by one at that edge; `din` is ignored.
- R4: With `clr_n` and `ld_n` high and either `en_p` or `en_t` low at a rising edge, `q` keeps its value.
- R5: `rco` is high exactly when `en_t` is high and `q` is all ones (4'b1111 at the default width); `en_p` has no effect on it.
- R6: A counting edge with `q` all ones gives `q` all zeros.
- R7: Clear has priority over load: with `clr_n` low, a rising edge with `ld_n` low leaves `q` at zero.
- R8: Two stages, with the upper stage's `en_t` driven by the lower stage's `rco` and all other inputs shared, behave as one 8-bit counter with the same load, count, hold and clear rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also qualifies the carry |
| din | input | WIDTH | Preset value for a load |
| q | output | WIDTH | Current count |
| rco | output | 1 | Carry out: high at all ones while `en_t` is high |

## Verification
The clocked properties assume that a clear pulse between two edges cancels the check of the following edge. A small flag, set by the clear and dropped by the next clock, suppresses those checks.

They also assume that every input is stable at each rising edge. The bench meets this by changing all inputs on the falling edge and sampling shortly after the rising edge. The only input it changes at other times is the clear, which it pulses in the middle of a cycle and releases before the next edge.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } cnt_mode_t;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import casc_cnt_pkg::*;
(
    input  logic      ld_n,
    input  logic      en_p,
    input  logic      en_t,
    output cnt_mode_t mode
);
    // Load wins over counting; counting needs both enables.
    always_comb begin
        if (!ld_n) begin
            mode = MODE_LOAD;
        end else if (en_p && en_t) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
    import casc_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_mode_t        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (mode)
            MODE_LOAD:  q_next = din;
            MODE_COUNT: q_next = q + ONE;
            MODE_HOLD:  q_next = q;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= ZERO;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             rco
);
    logic [WIDTH-1:0] ones_chain;

    assign ones_chain[0] = q[0];
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        assign ones_chain[i] = ones_chain[i-1] & q[i];
    end

    assign rco = en_t & ones_chain[WIDTH-1];
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
    import casc_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             rco
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_mode_t mode;

    cnt_mode_sel u_sel (
        .ld_n (ld_n),
        .en_p (en_p),
        .en_t (en_t),
        .mode (mode)
    );

    cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .mode  (mode),
        .din   (din),
        .q     (q)
    );

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .q    (q),
        .en_t (en_t),
        .rco  (rco)
    );

    // Set by a clear, dropped at the next clock: marks cycles whose edge checks a clear pulse has cancelled.
    logic clr_hit;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            clr_hit <= 1'b1;
        end else begin
            clr_hit <= 1'b0;
        end
    end

    p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> q == '0)
        else $error("clear did not hold q at zero");

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        !ld_n |=> q == $past(din))
        else $error("load did not take din");

    p_count_r3: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (ld_n && en_p && en_t) |=> q == $past(q) + ONE)
        else $error("count did not advance by one");

    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (ld_n && !(en_p && en_t)) |=> $stable(q))
        else $error("hold changed q");

    p_rco_r5: assert property (@(posedge clk) disable iff (!clr_n)
        rco |-> (en_t && (&q)))
        else $error("carry high without T or terminal count");

    p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (ld_n && en_p && rco) |=> q == '0)
        else $error("terminal count did not wrap to zero");
endmodule

// File: tb/tb_casc_bin_counter.sv
module tb_casc_bin_counter;
    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       ld_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] din = 4'h0;
    logic [3:0] q;
    logic       rco;

    // Cascade signals
    logic       c_clr_n = 1'b1;
    logic       c_ld_n = 1'b1;
    logic       c_en = 1'b0;
    logic [7:0] c_din = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       rco_lo, rco_hi;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    casc_bin_counter #(.WIDTH(4)) dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(q), .rco(rco)
    );

    casc_bin_counter #(.WIDTH(4)) c_lo (
        .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .en_p(c_en), .en_t(c_en),
        .din(c_din[3:0]), .q(q_lo), .rco(rco_lo)
    );

    casc_bin_counter #(.WIDTH(4)) c_hi (
        .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .en_p(c_en), .en_t(rco_lo),
        .din(c_din[7:4]), .q(q_hi), .rco(rco_hi)
    );

    // {ld_n, en_p, en_t, din[3:0], exp_q[3:0], exp_rco}
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 4'hE, 4'hE, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'hF, 1'b1},
        {1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},
        {1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h1, 1'b0},
        {1'b0, 1'b1, 1'b1, 4'h5, 4'h5, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'h9, 4'h6, 1'b0},
        {1'b1, 1'b0, 1'b0, 4'h0, 4'h6, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0},
        {1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        report();
    end

    initial begin
        logic [7:0] ref_cnt;
        // Reset
        #1 clr_n = 1'b0; c_clr_n = 1'b0;
        #2;
        check(q == 4'h0, "R1 reset q", int'(q), 0);
        check(rco == 1'b0, "R1 reset rco", int'(rco), 0);
        @(negedge clk);
        clr_n = 1'b1; c_clr_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {ld_n, en_p, en_t, din} = VEC[i][11:5];
            @(posedge clk);
            #2;
            check(q == VEC[i][4:1], $sformatf("vector %0d q (R2 R3 R4 R6)", i),
                  int'(q), int'(VEC[i][4:1]));
            check(rco == VEC[i][0], $sformatf("vector %0d rco R5", i),
                  int'(rco), int'(VEC[i][0]));
        end

        // R1: clear between edges acts at once
        @(negedge clk);
        ld_n = 1'b0; en_p = 1'b0; en_t = 1'b1; din = 4'hF;
        @(posedge clk);
        #2;
        check(q == 4'hF, "R2 preload before clear", int'(q), 15);
        ld_n = 1'b1;
        #1 clr_n = 1'b0;
        #1;
        check(q == 4'h0, "R1 clear between edges", int'(q), 0);
        check(rco == 1'b0, "R1 rco after clear", int'(rco), 0);

        // R7: clear held over an edge with load low
        @(negedge clk);
        ld_n = 1'b0; din = 4'hA; en_p = 1'b1; en_t = 1'b1;
        @(posedge clk);
        #2;
        check(q == 4'h0, "R7 clear beats load", int'(q), 0);
        #1 clr_n = 1'b1;
        @(posedge clk);
        #2;
        check(q == 4'hA, "R2 load after clear release", int'(q), 10);
        @(negedge clk);
        ld_n = 1'b1;
        @(posedge clk);
        #2;
        check(q == 4'hB, "R3 count after load", int'(q), 11);

        // R8: cascade against an 8-bit reference
        ref_cnt = 8'h00;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            c_en  = (i % 7) != 3;
            c_ld_n = !(i == 200 || i == 450);
            c_din = (i == 200) ? 8'hFB : 8'h3C;
            @(posedge clk);
            #2;
            if (!c_ld_n) ref_cnt = c_din;
            else if (c_en) ref_cnt = ref_cnt + 8'd1;
            check({q_hi, q_lo} == ref_cnt, $sformatf("R8 cascade cycle %0d", i),
                  int'({q_hi, q_lo}), int'(ref_cnt));
            if (i == 400) begin
                #1 c_clr_n = 1'b0;
                #1;
                ref_cnt = 8'h00;
                check({q_hi, q_lo} == 8'h00, "R8 cascade clear", int'({q_hi, q_lo}), 0);
                c_clr_n = 1'b1;
            end
        end
        check(rco_hi == (c_en && ({q_hi, q_lo} == 8'hFF)), "R8 cascade top carry",
              int'(rco_hi), int'(c_en && ({q_hi, q_lo} == 8'hFF)));

        report();
    end
endmodule